// File: doc/BRIEF.md
# Pushbutton-Stepped Serial Rate Selector

This block derives a serial bit-rate tick, and a sixteen-times oversampling tick for a receiver, from a fast system clock. The rate comes from a fixed list of ten standard serial rates. A user steps through the list with one active-low pushbutton and returns to the first entry with a second active-low pushbutton. The ordinal number of the chosen entry (1 to 10) drives two seven-segment digits.

A square rate clock with the same period as the bit tick goes to a monitor pin, so a scope or a neighbouring module can see it. It appears only while a monitor enable is high. The framing logic that uses the ticks sits outside this block.

Top module: `baud_sel`

## Requirements
- R1: After reset the selection index is 0, the ones digit shows 1 (segment code 0x06) and the tens digit is blank (0x00).
- R2: Each press of the step button (a high-to-low transition on `step_btn_n`, after synchronisation) advances the index by exactly one. Holding the button down for any length of time gives only one advance.
- R3: A step press while the index is 9 (the last entry) sets the index to 0.
- R4: A press of the home button sets the index to 0. When both buttons are seen pressed in the same cycle, the home button wins.
- R5: The entry at index i has rate 2400·2^i for i = 0..4 and 57600·2^(i-5) for i = 5..9. `bit_tick` is a one-cycle pulse with period round(CLK_HZ / rate) system cycles.
- R6: `os_tick` is a one-cycle pulse with period round(CLK_HZ / (16·rate)) system cycles, with a minimum of 1 (a pulse every cycle).
- R7: The segments show the ordinal index+1. Encoding is active-high, with bit 0 = a through bit 6 = g. Digits 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F. The tens digit is blank (0x00) below 10 and shows the tens digit otherwise.
- R8: While `mon_en` is high, `mon_clk` is high for ceil(P/2) cycles of each bit period P, starting in the cycle after a `bit_tick`. While `mon_en` is low, `mon_clk` is held low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_btn_n | input | 1 | Active-low step pushbutton |
| home_btn_n | input | 1 | Active-low return-to-first pushbutton |
| mon_en | input | 1 | Enables the monitor clock output |
| bit_tick | output | 1 | One-cycle pulse at the selected bit rate |
| os_tick | output | 1 | One-cycle pulse at 16x the selected bit rate |
| mon_clk | output | 1 | Gated square rate clock |
| sel_idx | output | 4 | Current selection index |
| seg_ones | output | 7 | Ones digit segments of the ordinal |
| seg_tens | output | 7 | Tens digit segments of the ordinal |

## Verification
The rate counters are measured at the slowest entry, the second entry and the fastest entry. These three settings separate a rounding mistake from a wrong table formula, and the fastest one exposes the clamp on the oversampling divisor. The button stimulus covers a long single press, repeated presses up to the wrap, a lone home press and a simultaneous press of both buttons. These separate edge detection from level sensing and show the priority order. The monitor is sampled with the enable both high and low, which tells apart a gated clock from a free-running one and checks its duty split.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

  // Rate of table entry idx: two geometric runs of doublings.
  function automatic int rate_of(input int idx, input int lo_rate,
                                 input int lo_count, input int hi_rate);
    if (idx < lo_count) return lo_rate << idx;
    return hi_rate << (idx - lo_count);
  endfunction

  // Nearest-integer division with a floor of one.
  function automatic int round_div(input int num, input int den);
    int q;
    q = (num + den / 2) / den;
    return (q < 1) ? 1 : q;
  endfunction

  // Active-high segment code, bit0 = a ... bit6 = g.
  function automatic logic [6:0] seg7(input int digit);
    case (digit)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic press
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], btn_n};
  end

  // Released in the older stage, pressed in the newer one.
  assign press = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/rate_div.sv
module rate_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             level
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] high_len;

  assign last     = div - DIV_W'(1);
  assign high_len = div - (div >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || cnt >= last) cnt <= '0;
    else                          cnt <= cnt + DIV_W'(1);
  end

  assign tick  = (cnt == last);
  assign level = (cnt < high_len);
endmodule

// File: rtl/baud_sel.sv
module baud_sel #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int NUM_RATES   = 10,
  parameter int LO_RATE     = 2400,
  parameter int LO_COUNT    = 5,
  parameter int HI_RATE     = 57600,
  parameter int OS_FACTOR   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_btn_n,
  input  logic       home_btn_n,
  input  logic       mon_en,
  output logic       bit_tick,
  output logic       os_tick,
  output logic       mon_clk,
  output logic [3:0] sel_idx,
  output logic [6:0] seg_ones,
  output logic [6:0] seg_tens
);
  import baud_sel_pkg::*;

  localparam int IDX_W = 4;
  localparam int DIV_W = $clog2(CLK_HZ / LO_RATE + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RATES - 1);

  // Named events for the checker.
  logic step_evt;
  logic home_evt;
  logic sel_chg;
  logic [IDX_W-1:0] idx_q;

  btn_edge #(.STAGES(SYNC_STAGES)) u_step (
    .clk(clk), .rst_n(rst_n), .btn_n(step_btn_n), .press(step_evt));
  btn_edge #(.STAGES(SYNC_STAGES)) u_home (
    .clk(clk), .rst_n(rst_n), .btn_n(home_btn_n), .press(home_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      sel_chg <= 1'b0;
    end else begin
      sel_chg <= step_evt | home_evt;
      if (home_evt)      idx_q <= '0;
      else if (step_evt) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
    end
  end

  // Divisor tables, computed at elaboration.
  logic [DIV_W-1:0] bit_tab [NUM_RATES];
  logic [DIV_W-1:0] os_tab  [NUM_RATES];
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tab
    localparam int RATE = rate_of(g, LO_RATE, LO_COUNT, HI_RATE);
    assign bit_tab[g] = DIV_W'(round_div(CLK_HZ, RATE));
    assign os_tab[g]  = DIV_W'(round_div(CLK_HZ, OS_FACTOR * RATE));
  end

  logic [DIV_W-1:0] bit_div;
  logic [DIV_W-1:0] os_div;
  always_comb begin
    bit_div = bit_tab[0];
    os_div  = os_tab[0];
    for (int i = 0; i < NUM_RATES; i++) begin
      if (idx_q == IDX_W'(i)) begin
        bit_div = bit_tab[i];
        os_div  = os_tab[i];
      end
    end
  end

  logic rate_level;
  logic os_level_unused;

  rate_div #(.DIV_W(DIV_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .restart(sel_chg), .div(bit_div),
    .tick(bit_tick), .level(rate_level));
  rate_div #(.DIV_W(DIV_W)) u_os (
    .clk(clk), .rst_n(rst_n), .restart(sel_chg), .div(os_div),
    .tick(os_tick), .level(os_level_unused));

  assign mon_clk = mon_en & rate_level;

  // Ordinal display.
  int ordinal;
  always_comb begin
    ordinal  = int'(idx_q) + 1;
    seg_ones = seg7(ordinal % 10);
    seg_tens = (ordinal / 10 == 0) ? 7'h00 : seg7(ordinal / 10);
  end

  assign sel_idx = idx_q;
endmodule

// File: rtl/baud_sel_chk.sv
module baud_sel_chk #(
  parameter int NUM_RATES = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       step_evt,
  input logic       home_evt,
  input logic [3:0] idx,
  input logic       mon_en,
  input logic       mon_clk
);
  localparam logic [3:0] LAST = 4'(NUM_RATES - 1);

  a_r2_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !home_evt && idx != LAST) |=> (idx == $past(idx) + 4'd1));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !home_evt) |=> $stable(idx));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !home_evt && idx == LAST) |=> (idx == 4'd0));

  a_r4_home_wins: assert property (@(posedge clk) disable iff (!rst_n)
    home_evt |=> (idx == 4'd0));

  a_r5_idx_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);

  a_r8_mon_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> !mon_clk);
endmodule

bind baud_sel baud_sel_chk #(.NUM_RATES(NUM_RATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_evt(step_evt), .home_evt(home_evt),
  .idx(idx_q), .mon_en(mon_en), .mon_clk(mon_clk));

// File: tb/tb_baud_sel.sv
module tb_baud_sel;
  localparam int CLK_HZ = 5_000_000;

  logic clk = 0;
  logic rst_n = 0;
  logic step_btn_n = 1;
  logic home_btn_n = 1;
  logic mon_en = 0;
  logic bit_tick, os_tick, mon_clk;
  logic [3:0] sel_idx;
  logic [6:0] seg_ones, seg_tens;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  baud_sel #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .step_btn_n(step_btn_n), .home_btn_n(home_btn_n),
    .mon_en(mon_en), .bit_tick(bit_tick), .os_tick(os_tick), .mon_clk(mon_clk),
    .sel_idx(sel_idx), .seg_ones(seg_ones), .seg_tens(seg_tens));

  int rates [10] = '{2400, 4800, 9600, 19200, 38400, 57600, 115200, 230400, 460800, 921600};
  logic [6:0] segs [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  function automatic int exp_div(int idx, int factor);
    real r;
    int d;
    r = real'(CLK_HZ) / (real'(rates[idx]) * factor);
    d = $rtoi(r + 0.5);
    return (d < 1) ? 1 : d;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboards for tick intervals.
  int bit_q[$];
  int os_q[$];
  bit bit_started = 0, os_started = 0;
  int bit_gap = 0, os_gap = 0;

  always @(negedge clk) begin
    bit_gap++;
    os_gap++;
    if (bit_tick) begin
      if (bit_started && bit_q.size() > 0) check("R5 bit period", bit_gap, bit_q.pop_front());
      bit_started = 1;
      bit_gap = 0;
    end
    if (os_tick) begin
      if (os_started && os_q.size() > 0) check("R6 os period", os_gap, os_q.pop_front());
      os_started = 1;
      os_gap = 0;
    end
  end

  task automatic expect_periods(int idx, int n);
    @(negedge clk);
    bit_started = 0;
    os_started = 0;
    for (int k = 0; k < n; k++) begin
      bit_q.push_back(exp_div(idx, 1));
      os_q.push_back(exp_div(idx, 16));
    end
    while (bit_q.size() > 0 || os_q.size() > 0) @(negedge clk);
  endtask

  task automatic press(bit step, bit home);
    @(negedge clk);
    if (step) step_btn_n = 0;
    if (home) home_btn_n = 0;
    repeat (20) @(negedge clk);
    step_btn_n = 1;
    home_btn_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_segs(string req, int idx);
    int ord;
    ord = idx + 1;
    check(req, seg_ones, segs[ord % 10]);
    check(req, seg_tens, (ord / 10 == 0) ? 0 : segs[ord / 10]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idx", sel_idx, 0);
    check("R1 ones", seg_ones, 7'h06);
    check("R1 tens", seg_tens, 0);
    check("R8 mon off at reset", mon_clk, 0);

    expect_periods(0, 2);                 // R5/R6 slowest entry

    press(1, 0);                          // long single press
    check("R2 one advance", sel_idx, 1);
    check_segs("R7 idx1", 1);
    expect_periods(1, 2);

    press(1, 0);
    check("R2 second press", sel_idx, 2);
    check_segs("R7 idx2", 2);

    // R8 monitor enabled: high for ceil(P/2) of one period
    begin
      int highs = 0;
      int p = exp_div(2, 1);
      mon_en = 1;
      @(negedge clk);
      while (!bit_tick) @(negedge clk);
      for (int k = 0; k < p; k++) begin
        @(negedge clk);
        if (mon_clk) highs++;
      end
      check("R8 mon high count", highs, p - p / 2);
      mon_en = 0;
      highs = 0;
      for (int k = 0; k < 2 * p; k++) begin
        @(negedge clk);
        if (mon_clk) highs++;
      end
      check("R8 mon gated low", highs, 0);
    end

    for (int k = 0; k < 7; k++) press(1, 0);
    check("R2 reach last", sel_idx, 9);
    check_segs("R7 idx9", 9);
    expect_periods(9, 3);                 // fastest entry, os clamped

    press(1, 0);
    check("R3 wrap", sel_idx, 0);
    check_segs("R7 wrap", 0);

    press(1, 0);
    press(1, 0);
    check("R2 before home", sel_idx, 2);
    press(0, 1);
    check("R4 home", sel_idx, 0);

    press(1, 0);
    press(1, 0);
    press(1, 0);
    press(1, 1);
    check("R4 home beats step", sel_idx, 0);
    expect_periods(0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule